// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Front End

This block sits between the asynchronous control pins of a byte-wide parallel flash part and the synchronous logic that models its storage and command handling. It samples the active-low chip select, output enable and write enable lines, together with the address and write data buses, on a fast system clock. It then works out what the bus is doing: idling in standby, reading, writing a byte, or selected with its outputs off.

During a recognised read, the block drives the byte supplied by the storage model onto its data output and raises an output-enable flag. At all other times the data output is released (flag low, data zero). For every completed write bus cycle it emits one clock-wide strobe with the captured address and byte. The address is taken when the second of chip select and write enable goes low. The byte is taken when the first of the two goes high. A write is therefore handled the same way whether chip select or write enable frames it. The synchronised address is also passed on, so the storage model can look up read data.

Top module: `flash_bus_if`

## Requirements
- R1: `dout_en_o` is 1 and `dout_o` equals `rdata_i` only while a recognised read is in progress with the synchronised chip select low, output enable low and write enable high; otherwise `dout_en_o` is 0 and `dout_o` is 0. Write enable falling during a read ends it.
- R2: A read is recognised only if write enable is already high in the sample where chip select and output enable first become low together. If write enable is low then, no read occurs until chip select or output enable returns high, even if write enable rises meanwhile.
- R3: After chip select or output enable rises at the pins, `dout_en_o` stays 1 through the first SYNC_STAGES-1 clock edges and is 0 after SYNC_STAGES edges.
- R4: With chip select high, `mode_o` is 0 (standby) and `dout_en_o` is 0, whatever output enable does.
- R5: `mode_o` encodes 0 = standby, 1 = read (driving), 2 = write (chip select low, write enable low, output enable high), 3 = selected with output disabled (any other state with chip select low).
- R6: The write address is the address bus value in the sample where the combined chip-select/write-enable low condition begins; later address changes in the same cycle are ignored.
- R7: The write byte is the data bus value in the sample where chip select or write enable, whichever is first, returns high.
- R8: A write framed by chip select (write enable low first) yields the same strobe, address and byte as one framed by write enable.
- R9: A write cycle is ignored, with no strobe, if output enable is low when the cycle starts or at any time before it completes.
- R10: Each completed write produces exactly one `wr_stb_o` pulse, one clock wide, with `wr_addr_o` and `wr_data_o` valid then and held until the next write.
- R11: `rd_addr_o` shows the address bus after SYNC_STAGES clock edges.
- R12: While reset is asserted, all outputs are 0 (`mode_o` standby, no strobe, no drive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip select pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| addr_i | input | ADDR_W | Address bus pins |
| wdata_i | input | DATA_W | Data bus pins as written by the host |
| rdata_i | input | DATA_W | Byte from the storage model for `rd_addr_o` |
| dout_o | output | DATA_W | Data driven to the bus, 0 when released |
| dout_en_o | output | 1 | High when the data pins are driven |
| mode_o | output | 2 | Decoded bus mode (see R5) |
| rd_addr_o | output | ADDR_W | Synchronised address for read lookup |
| wr_stb_o | output | 1 | One-cycle pulse per completed write |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write byte |

## Verification
The bench builds the block with a 17-bit address, an 8-bit byte and a two-stage synchroniser. The shallow synchroniser lets the exact edge on which the drive drops after a release be checked on both sides of the boundary. The wide address lets the captured and the later, ignored address values differ in high bits. The bench's model reads its synchroniser depth from the same parameter, so the per-cycle comparison also follows other depths.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

  typedef enum logic [1:0] {
    FB_STANDBY = 2'd0,
    FB_READ    = 2'd1,
    FB_WRITE   = 2'd2,
    FB_OUTDIS  = 2'd3
  } fbi_mode_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } fbi_ctl_t;

  localparam int CTL_W = 3;

endpackage

// File: rtl/fbi_sync.sv
module fbi_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign stg_d[gi] = d_i;
      end else begin : g_rest
        assign stg_d[gi] = stg_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/fbi_read_ctl.sv
module fbi_read_ctl
  import fbi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fbi_ctl_t          ctl_i,
  input  fbi_ctl_t          ctl_prev_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              drive_o,
  output logic [DATA_W-1:0] dout_o,
  output fbi_mode_e         mode_o
);

  logic both_lo_cur;
  logic both_lo_prev;
  logic rd_q;
  logic rd_d;

  assign both_lo_cur  = ~ctl_i.ce_n & ~ctl_i.oe_n;
  assign both_lo_prev = ~ctl_prev_i.ce_n & ~ctl_prev_i.oe_n;

  // A read opens only on the sample where CE/OE become jointly low with WE high,
  // and persists while that holds.
  always_comb begin
    rd_d = both_lo_cur & ctl_i.we_n & (rd_q | ~both_lo_prev);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_d;
  end

  assign drive_o = rd_q & both_lo_cur & ctl_i.we_n;
  assign dout_o  = drive_o ? rdata_i : '0;

  always_comb begin
    if (ctl_i.ce_n)                    mode_o = FB_STANDBY;
    else if (drive_o)                  mode_o = FB_READ;
    else if (!ctl_i.we_n && ctl_i.oe_n) mode_o = FB_WRITE;
    else                               mode_o = FB_OUTDIS;
  end

  // R1: an open read implies the previous sample had a valid read pin state
  assert_read_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> ($past(both_lo_cur) && $past(ctl_i.we_n)));

  // R2: a read may only start from a non-read state with WE already high
  assert_read_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_q) |-> ($past(ctl_i.we_n) && !$past(both_lo_prev)));

  // R3: a release of CE or OE closes the read at the next edge
  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.ce_n || ctl_i.oe_n) |=> !rd_q);

endmodule

// File: rtl/fbi_wr_capture.sv
module fbi_wr_capture
  import fbi_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fbi_ctl_t          ctl_i,
  input  fbi_ctl_t          ctl_prev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              cw_cur;
  logic              cw_prev;
  logic              busy_q, busy_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_en;
  logic              data_en;

  assign cw_cur  = ~ctl_i.ce_n & ~ctl_i.we_n;
  assign cw_prev = ~ctl_prev_i.ce_n & ~ctl_prev_i.we_n;

  // Later falling of CE/WE == start of joint-low; first rising == its end.
  always_comb begin
    busy_d  = busy_q;
    stb_d   = 1'b0;
    addr_en = 1'b0;
    data_en = 1'b0;
    if (!busy_q) begin
      if (cw_cur && !cw_prev && ctl_i.oe_n) begin
        busy_d  = 1'b1;
        addr_en = 1'b1;
      end
    end else if (!ctl_i.oe_n) begin
      busy_d = 1'b0;
    end else if (!cw_cur) begin
      busy_d  = 1'b0;
      stb_d   = 1'b1;
      data_en = 1'b1;
    end
  end

  always_comb begin
    addr_d = addr_en ? addr_i : addr_q;
    data_d = data_en ? data_i : data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      stb_q  <= stb_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R10: strobe is exactly one clock wide
  assert_stb_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  // R9: no strobe unless OE was high on the completing sample
  assert_stb_oe_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(ctl_i.oe_n));

  // R6: address frozen while a write cycle stays open
  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(addr_q));

  // R7: byte changes only together with a strobe
  assert_data_with_stb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> stb_q);

endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import fbi_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic [1:0]        mode_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int BUS_W = CTL_W + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sh_q <= 2'b00;
    else         rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n = rst_sh_q[1];

  logic [BUS_W-1:0]  bus_raw;
  logic [BUS_W-1:0]  bus_s;
  fbi_ctl_t          ctl_s;
  fbi_ctl_t          ctl_prev_q;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  fbi_mode_e         mode;

  assign bus_raw = {ce_ni, oe_ni, we_ni, addr_i, wdata_i};

  fbi_sync #(
    .W       (BUS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (BUS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (bus_raw),
    .q_o    (bus_s)
  );

  assign ctl_s  = fbi_ctl_t'(bus_s[BUS_W-1 -: CTL_W]);
  assign addr_s = bus_s[DATA_W +: ADDR_W];
  assign data_s = bus_s[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctl_prev_q <= fbi_ctl_t'(3'b111);
    else        ctl_prev_q <= ctl_s;
  end

  fbi_read_ctl #(
    .DATA_W (DATA_W)
  ) u_read (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ctl_i      (ctl_s),
    .ctl_prev_i (ctl_prev_q),
    .rdata_i    (rdata_i),
    .drive_o    (dout_en_o),
    .dout_o     (dout_o),
    .mode_o     (mode)
  );

  fbi_wr_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_write (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ctl_i      (ctl_s),
    .ctl_prev_i (ctl_prev_q),
    .addr_i     (addr_s),
    .data_i     (data_s),
    .stb_o      (wr_stb_o),
    .addr_o     (wr_addr_o),
    .data_o     (wr_data_o)
  );

  assign mode_o    = mode;
  assign rd_addr_o = addr_s;

  // R4: standby never drives the data pins
  assert_standby_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_o == 2'd0) |-> !dout_en_o);

  // R5: write mode is never reported while driving
  assert_mode_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    dout_en_o |-> (mode_o == 2'd1));

endmodule

// File: tb/flash_bus_if_bench.sv
module flash_bus_if_bench;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int S  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic [1:0]    mode;
  logic [AW-1:0] rd_addr;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  flash_bus_if #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(S)) u_flash_bus_if (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_i(rdata),
    .dout_o(dout), .dout_en_o(dout_en), .mode_o(mode), .rd_addr_o(rd_addr),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int stb_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: history of pin samples, one per clock edge
  typedef struct { bit ce; bit oe; bit we; int a; int d; } smp_t;
  smp_t hist[$];
  bit   m_rd, m_busy, m_stb;
  int   m_waddr, m_wdata;

  function automatic smp_t idle_smp();
    smp_t t;
    t.ce = 1; t.oe = 1; t.we = 1; t.a = 0; t.d = 0;
    return t;
  endfunction

  always @(posedge clk) begin
    smp_t pin, cur, prv, now;
    bit   drv, bl_c, bl_p, cw_c, cw_p;
    int   exp_mode;
    pin.ce = ce_n; pin.oe = oe_n; pin.we = we_n; pin.a = int'(addr); pin.d = int'(wdata);
    if (!rst_ni) begin
      hist.delete();
      for (int i = 0; i < S + 2; i++) hist.push_back(idle_smp());
      m_rd = 0; m_busy = 0; m_stb = 0; m_waddr = 0; m_wdata = 0;
    end else begin
      hist.push_front(pin);
      void'(hist.pop_back());
      cur  = hist[S];
      prv  = hist[S+1];
      bl_c = !cur.ce && !cur.oe;
      bl_p = !prv.ce && !prv.oe;
      cw_c = !cur.ce && !cur.we;
      cw_p = !prv.ce && !prv.we;
      m_rd = bl_c && cur.we && (m_rd || !bl_p);
      m_stb = 0;
      if (!m_busy) begin
        if (cw_c && !cw_p && cur.oe) begin m_busy = 1; m_waddr = cur.a; end
      end else if (!cur.oe) begin
        m_busy = 0;
      end else if (!cw_c) begin
        m_busy = 0; m_stb = 1; m_wdata = cur.d;
      end
    end
    #2;
    now = hist[S-1];
    drv = m_rd && !now.ce && !now.oe && now.we;
    if (now.ce)               exp_mode = 0;
    else if (drv)             exp_mode = 1;
    else if (!now.we && now.oe) exp_mode = 2;
    else                      exp_mode = 3;
    chk(dout_en === drv, "R1 dout_en", dout_en, drv);
    chk(dout === (drv ? rdata : '0), "R1 dout", dout, drv ? rdata : 0);
    chk(mode === 2'(exp_mode), "R5 mode", mode, exp_mode);
    chk(rd_addr === AW'(now.a), "R11 rd_addr", rd_addr, now.a);
    chk(wr_stb === m_stb, "R10 wr_stb", wr_stb, m_stb);
    chk(wr_addr === AW'(m_waddr), "R6 wr_addr", wr_addr, m_waddr);
    chk(wr_data === DW'(m_wdata), "R7 wr_data", wr_data, m_wdata);
    if (wr_stb === 1'b1) stb_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    idle(); addr = '0; wdata = '0; rdata = '0; rst_ni = 0;
    cyc(3);
    // R12: outputs quiet under reset
    chk(dout_en === 0 && mode === 2'd0 && wr_stb === 0, "R12 reset state", {dout_en, mode, wr_stb}, 0);
    chk(wr_addr === '0 && wr_data === '0, "R12 reset capture", wr_addr, 0);
    rst_ni = 1;
    cyc(6);

    // WE-framed write (R6, R7, R10)
    base = stb_cnt;
    addr = 17'h05555; wdata = 8'h11; ce_n = 0; cyc(3);
    we_n = 0; cyc(4);
    addr = 17'h1ABCD; wdata = 8'hA5; cyc(4);
    we_n = 1; cyc(1);
    wdata = 8'h3C; cyc(3);
    ce_n = 1; cyc(S + 4);
    chk(stb_cnt == base + 1, "R10 one strobe WE-framed", stb_cnt - base, 1);
    chk(wr_addr === 17'h05555, "R6 address at later fall", wr_addr, 17'h05555);
    chk(wr_data === 8'hA5, "R7 data at first rise", wr_data, 8'hA5);

    // CE-framed write (R8)
    base = stb_cnt;
    we_n = 0; cyc(3);
    addr = 17'h02AAA; ce_n = 0; cyc(4);
    addr = 17'h1F00F; wdata = 8'h5A; cyc(3);
    ce_n = 1; cyc(1);
    wdata = 8'h00; we_n = 1; cyc(S + 4);
    chk(stb_cnt == base + 1, "R8 one strobe CE-framed", stb_cnt - base, 1);
    chk(wr_addr === 17'h02AAA, "R8 CE-framed address", wr_addr, 17'h02AAA);
    chk(wr_data === 8'h5A, "R8 CE-framed data", wr_data, 8'h5A);

    // OE low from the start: ignored (R9)
    base = stb_cnt;
    addr = 17'h00777; wdata = 8'hEE;
    oe_n = 0; ce_n = 0; we_n = 0; cyc(5);
    idle(); cyc(S + 4);
    chk(stb_cnt == base, "R9 write with OE low", stb_cnt - base, 0);
    chk(wr_addr === 17'h02AAA, "R9 address untouched", wr_addr, 17'h02AAA);

    // OE dropping mid-write aborts it (R9)
    base = stb_cnt;
    ce_n = 0; we_n = 0; cyc(4);
    oe_n = 0; cyc(3);
    oe_n = 1; cyc(3);
    idle(); cyc(S + 4);
    chk(stb_cnt == base, "R9 OE dip aborts write", stb_cnt - base, 0);

    // write mode code, then strobe on completion (R5, R10)
    base = stb_cnt;
    addr = 17'h10001; wdata = 8'h77;
    ce_n = 0; we_n = 0; cyc(S + 1);
    chk(mode === 2'd2, "R5 write mode code", mode, 2);
    idle(); cyc(S + 4);
    chk(stb_cnt == base + 1 && wr_data === 8'h77, "R10 strobe after write", stb_cnt - base, 1);

    // read (R1, R5, R11, R3)
    rdata = 8'hC3; addr = 17'h00123;
    ce_n = 0; oe_n = 0; cyc(S + 2);
    chk(dout_en === 1, "R1 read drives", dout_en, 1);
    chk(dout === 8'hC3, "R1 read data", dout, 8'hC3);
    chk(mode === 2'd1, "R5 read mode code", mode, 1);
    chk(rd_addr === 17'h00123, "R11 read address", rd_addr, 17'h00123);
    oe_n = 1; cyc(S - 1);
    chk(dout_en === 1, "R3 drive before release reaches", dout_en, 1);
    cyc(1);
    chk(dout_en === 0 && dout === '0, "R3 release by OE", dout_en, 0);
    oe_n = 0; cyc(S + 2);
    ce_n = 1; cyc(S);
    chk(dout_en === 0, "R3 release by CE", dout_en, 0);
    idle(); cyc(3);

    // WE low when CE/OE go low: no read even after WE rises (R2)
    we_n = 0; ce_n = 0; oe_n = 0; cyc(4);
    we_n = 1; cyc(6);
    chk(dout_en === 0, "R2 no read without WE high first", dout_en, 0);
    chk(mode === 2'd3, "R5 output disabled code", mode, 3);
    oe_n = 1; cyc(3);
    oe_n = 0; cyc(S + 3);
    chk(dout_en === 1, "R2 read after re-arm", dout_en, 1);
    we_n = 0; cyc(S);
    chk(dout_en === 0, "R1 WE fall ends read", dout_en, 0);
    we_n = 1; cyc(S + 3);
    chk(dout_en === 0, "R2 WE return does not resume", dout_en, 0);
    idle(); cyc(3);

    // standby ignores OE (R4)
    oe_n = 0; cyc(5);
    chk(dout_en === 0 && mode === 2'd0, "R4 standby with OE low", {dout_en, mode}, 0);
    idle(); cyc(5);

    finish_run();
  end

endmodule